// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps 64-bit local addresses headed for a serial link onto link-side addresses. It uses a fixed set of programmable windows; eight by default. Each window holds a compare value, a mask, a replacement value and a transaction-type word. Software programs them through a simple 32-bit register write/read port. Bit 0 of a window's low compare word arms that window. Because of this, software loads every other field first and sets that bit last.

A lookup is purely combinational. The caller presents an address and gets back four results in the same cycle:
- whether any window claimed the address;
- which window claimed it;
- the rewritten address;
- whether the transaction is to be issued as I/O or as memory.

One input gates all matching globally. A second input makes a request skip the windows and leave untranslated. Issuing the resulting transaction is left to the logic downstream.

Top module: `oaw_xlat`

## Requirements
- R1: After reset every window register reads 0. No window hits, so a lookup returns hit_o=0, win_idx_o=0, is_io_o=0 and xlat_addr_o equal to the input address.
- R2: Window w owns byte offsets w*0x20 through w*0x20+0x1F on the register port, with fields at these offsets:
  - compare-low at +0x00, compare-high at +0x04;
  - replacement-low at +0x08, replacement-high at +0x0C;
  - mask-low at +0x10, mask-high at +0x14;
  - type word at +0x18.
  
  A write updates the field on the next clock edge, and reading the same offset returns it. Offset +0x1C reads 0 and ignores writes. An access whose byte address has bits [1:0] not zero does nothing and reads 0.
- R3: A window takes part in matching only while bit 0 of its compare-low word is 1. Clearing that bit disables the window without disturbing its other fields.
- R4: An enabled window hits when (address AND mask) equals (compare AND mask) over all 64 bits. The mask is {mask-high, mask-low}, the compare value is {compare-high, compare-low}, and compare bit 0 is treated as 0 in this comparison.
- R5: On a hit the output address is (replacement AND mask) OR (address AND NOT mask).
- R6: When more than one window hits, the lowest-numbered one is reported and used.
- R7: When nothing hits, hit_o=0, win_idx_o=0, is_io_o=0 and xlat_addr_o equals the input address.
- R8: With win_en_i=0, no window hits, whatever is programmed.
- R9: With bypass_i=1, no window hits and the address passes through unchanged.
- R10: The transaction type is type-word bits [3:0]. Value 0x4 reports is_io_o=1. Value 0x0, and every other value, reports memory (is_io_o=0).
- R11: Window registers change only on a register write. Lookups and idle cycles leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | IDX_W+5 | Register byte address, used for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at reg_addr_i (combinational) |
| win_en_i | input | 1 | Global enable for window matching |
| bypass_i | input | 1 | Skip translation for this request |
| lookup_addr_i | input | 64 | Local address to translate |
| hit_o | output | 1 | A window claimed the address |
| win_idx_o | output | IDX_W | Index of the claiming window |
| xlat_addr_o | output | 64 | Translated (or passed-through) address |
| is_io_o | output | 1 | 1 for I/O, 0 for memory |

## Verification
The bench probes the edges of a 128 MiB window on its top five low-word bits. If the mask is applied to one side only, the window hits one address past either edge or misses its own last byte. A window with a zero high mask must translate an address with nonzero upper bits and keep those bits. A design that compares the upper word, or zeroes it, would miss that address or drop those bits.

Compare bit 0 doubles as the arm bit, so a window with a full mask is looked up at an even and an odd address. A design that compares that bit literally inverts the result.

Two overlapping windows test the priority rule. Disarming the winner must hand the address to the other window, which uses a different remap and a different type. A reversed priority scan shows up as the wrong index and the wrong address.

On the register side, the bench writes to the unused slot and makes a misaligned write. Either one would corrupt a neighbouring field in a design that decodes loosely.

// File: rtl/oaw_pkg.sv
package oaw_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned LA_W   = 64;
  localparam int unsigned NFLD   = 7;
  localparam int unsigned TYPE_W = 4;

  typedef enum logic [2:0] {
    F_CMP_LO  = 3'd0,
    F_CMP_HI  = 3'd1,
    F_REPL_LO = 3'd2,
    F_REPL_HI = 3'd3,
    F_MASK_LO = 3'd4,
    F_MASK_HI = 3'd5,
    F_TYPE    = 3'd6
  } fld_e;

  localparam logic [TYPE_W-1:0] TYPE_MEM = 4'h0;
  localparam logic [TYPE_W-1:0] TYPE_IO  = 4'h4;
endpackage

// File: rtl/oaw_regfile.sv
module oaw_regfile
  import oaw_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [IDX_W+4:0]                addr_i,
  input  logic [WORD_W-1:0]               wdata_i,
  output logic [WORD_W-1:0]               rdata_o,
  output logic [NWIN-1:0][LA_W-1:0]       cmp_o,
  output logic [NWIN-1:0][LA_W-1:0]       mask_o,
  output logic [NWIN-1:0][LA_W-1:0]       repl_o,
  output logic [NWIN-1:0][TYPE_W-1:0]     type_o
);
  logic [WORD_W-1:0] regs_q [NWIN][NFLD];
  logic [IDX_W-1:0]  win_sel;
  logic [2:0]        fld_sel;
  logic              aligned;

  assign win_sel = addr_i[IDX_W+4:5];
  assign fld_sel = addr_i[4:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    for (genvar f = 0; f < NFLD; f++) begin : g_fld
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          regs_q[w][f] <= '0;
        end else if (we_i && aligned && win_sel == IDX_W'(w) && fld_sel == 3'(f)) begin
          regs_q[w][f] <= wdata_i;
        end
      end
    end
    assign cmp_o[w]  = {regs_q[w][F_CMP_HI],  regs_q[w][F_CMP_LO]};
    assign mask_o[w] = {regs_q[w][F_MASK_HI], regs_q[w][F_MASK_LO]};
    assign repl_o[w] = {regs_q[w][F_REPL_HI], regs_q[w][F_REPL_LO]};
    assign type_o[w] = regs_q[w][F_TYPE][TYPE_W-1:0];
  end

  // slot 7 of each block is a hole
  always_comb begin
    rdata_o = '0;
    if (aligned && fld_sel < 3'(NFLD)) rdata_o = regs_q[win_sel][fld_sel];
  end
endmodule

// File: rtl/oaw_win_match.sv
module oaw_win_match
  import oaw_pkg::*;
(
  input  logic [LA_W-1:0]   cmp_i,
  input  logic [LA_W-1:0]   mask_i,
  input  logic [LA_W-1:0]   repl_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [LA_W-1:0]   addr_i,
  output logic              hit_o,
  output logic [LA_W-1:0]   xlat_o,
  output logic              is_io_o
);
  logic [LA_W-1:0] cmp_val;

  // bit 0 arms the window and is not part of the compare value
  assign cmp_val = {cmp_i[LA_W-1:1], 1'b0};
  assign hit_o   = cmp_i[0] && ((addr_i & mask_i) == (cmp_val & mask_i));
  assign xlat_o  = (repl_i & mask_i) | (addr_i & ~mask_i);
  assign is_io_o = (type_i == TYPE_IO);
endmodule

// File: rtl/oaw_prio_sel.sv
module oaw_prio_sel
  import oaw_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic [NWIN-1:0]           hit_i,
  input  logic [NWIN-1:0][LA_W-1:0] xlat_i,
  input  logic [NWIN-1:0]           io_i,
  input  logic [LA_W-1:0]           addr_i,
  output logic                      hit_o,
  output logic [IDX_W-1:0]          idx_o,
  output logic [LA_W-1:0]           xlat_o,
  output logic                      is_io_o
);
  // scan high to low so the lowest hitting index is written last
  always_comb begin
    hit_o   = |hit_i;
    idx_o   = '0;
    xlat_o  = addr_i;
    is_io_o = 1'b0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        idx_o   = IDX_W'(i);
        xlat_o  = xlat_i[i];
        is_io_o = io_i[i];
      end
    end
  end
endmodule

// File: rtl/oaw_xlat.sv
module oaw_xlat
  import oaw_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [IDX_W+4:0]   reg_addr_i,
  input  logic [WORD_W-1:0]  reg_wdata_i,
  output logic [WORD_W-1:0]  reg_rdata_o,
  input  logic               win_en_i,
  input  logic               bypass_i,
  input  logic [LA_W-1:0]    lookup_addr_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   win_idx_o,
  output logic [LA_W-1:0]    xlat_addr_o,
  output logic               is_io_o
);
  logic [NWIN-1:0][LA_W-1:0]   cmp_w, mask_w, repl_w, xlat_w;
  logic [NWIN-1:0][TYPE_W-1:0] type_w;
  logic [NWIN-1:0]             raw_hit, gated_hit, io_w;
  logic                        lookup_on;

  oaw_regfile #(.NWIN(NWIN), .IDX_W(IDX_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .cmp_o   (cmp_w),
    .mask_o  (mask_w),
    .repl_o  (repl_w),
    .type_o  (type_w)
  );

  for (genvar w = 0; w < NWIN; w++) begin : g_match
    oaw_win_match u_match (
      .cmp_i   (cmp_w[w]),
      .mask_i  (mask_w[w]),
      .repl_i  (repl_w[w]),
      .type_i  (type_w[w]),
      .addr_i  (lookup_addr_i),
      .hit_o   (raw_hit[w]),
      .xlat_o  (xlat_w[w]),
      .is_io_o (io_w[w])
    );
  end

  assign lookup_on = win_en_i && !bypass_i;
  assign gated_hit = raw_hit & {NWIN{lookup_on}};

  oaw_prio_sel #(.NWIN(NWIN), .IDX_W(IDX_W)) u_sel (
    .hit_i   (gated_hit),
    .xlat_i  (xlat_w),
    .io_i    (io_w),
    .addr_i  (lookup_addr_i),
    .hit_o   (hit_o),
    .idx_o   (win_idx_o),
    .xlat_o  (xlat_addr_o),
    .is_io_o (is_io_o)
  );
endmodule

// File: rtl/oaw_xlat_chk.sv
module oaw_xlat_chk
  import oaw_pkg::*;
#(
  parameter int unsigned NWIN  = 8,
  parameter int unsigned IDX_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      reg_we_i,
  input logic                      win_en_i,
  input logic                      bypass_i,
  input logic [LA_W-1:0]           lookup_addr_i,
  input logic                      hit_o,
  input logic [IDX_W-1:0]          win_idx_o,
  input logic [LA_W-1:0]           xlat_addr_o,
  input logic                      is_io_o,
  input logic [NWIN-1:0][LA_W-1:0] cmp_q,
  input logic [NWIN-1:0][LA_W-1:0] mask_q
);
  assert_armed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> cmp_q[win_idx_o][0]);

  assert_compare_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (((lookup_addr_i ^ cmp_q[win_idx_o]) & mask_q[win_idx_o] & ~64'h1) == '0));

  assert_keep_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (((xlat_addr_o ^ lookup_addr_i) & ~mask_q[win_idx_o]) == '0));

  assert_miss_pass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (xlat_addr_o == lookup_addr_i && win_idx_o == '0 && !is_io_o));

  assert_global_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |-> !hit_o);

  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> !hit_o);

  assert_regs_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_we_i |=> ($stable(cmp_q) && $stable(mask_q)));
endmodule

bind oaw_xlat oaw_xlat_chk #(.NWIN(NWIN), .IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .win_en_i      (win_en_i),
  .bypass_i      (bypass_i),
  .lookup_addr_i (lookup_addr_i),
  .hit_o         (hit_o),
  .win_idx_o     (win_idx_o),
  .xlat_addr_o   (xlat_addr_o),
  .is_io_o       (is_io_o),
  .cmp_q         (cmp_w),
  .mask_q        (mask_w)
);

// File: tb/tb_oaw_xlat.sv
`timescale 1ns/1ps
module tb_oaw_xlat;
  localparam int NWIN = 8;
  localparam int IDX_W = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  raddr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        en = 1'b0;
  logic        byp = 1'b0;
  logic [63:0] la = '0;
  logic        hit;
  logic [2:0]  idx;
  logic [63:0] xa;
  logic        io;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  oaw_xlat #(.NWIN(NWIN), .IDX_W(IDX_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(raddr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .win_en_i(en), .bypass_i(byp),
    .lookup_addr_i(la), .hit_o(hit), .win_idx_o(idx), .xlat_addr_o(xa), .is_io_o(io)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk);
    raddr = a;
    #1;
    chk(req, {32'h0, rdata}, {32'h0, exp});
  endtask

  task automatic look(string req, logic [63:0] a, logic eh, logic [2:0] ei,
                      logic [63:0] ex, logic eio);
    @(negedge clk);
    la = a;
    #1;
    chk({req, " hit"}, {63'h0, hit}, {63'h0, eh});
    chk({req, " idx"}, {61'h0, idx}, {61'h0, ei});
    chk({req, " addr"}, xa, ex);
    chk({req, " io"}, {63'h0, io}, {63'h0, eio});
  endtask

  // fields written with arm bit clear, arm last when requested
  task automatic set_win(int w, logic [31:0] clo, logic [31:0] chi, logic [31:0] rlo,
                         logic [31:0] rhi, logic [31:0] klo, logic [31:0] khi,
                         logic [31:0] typ, logic arm);
    logic [7:0] b;
    b = 8'(w * 32);
    wr(b + 8'h00, clo & ~32'h1);
    wr(b + 8'h04, chi);
    wr(b + 8'h08, rlo);
    wr(b + 8'h0C, rhi);
    wr(b + 8'h10, klo);
    wr(b + 8'h14, khi);
    wr(b + 8'h18, typ);
    if (arm) wr(b + 8'h00, clo | 32'h1);
  endtask

  task automatic t_reset;
    rd_chk("R1 reset cmp_lo w0", 8'h00, 32'h0);
    rd_chk("R1 reset type w7", 8'hF8, 32'h0);
    look("R1 reset lookup", 64'h0000_0000_E812_3456, 1'b0, 3'd0, 64'h0000_0000_E812_3456, 1'b0);
  endtask

  task automatic t_regmap;
    set_win(4, 32'h1111_1110, 32'h2222_2222, 32'h3333_3333, 32'h4444_4444,
            32'h5555_5555, 32'h6666_6666, 32'h7777_7777, 1'b0);
    rd_chk("R2 cmp_lo", 8'h80, 32'h1111_1110);
    rd_chk("R2 cmp_hi", 8'h84, 32'h2222_2222);
    rd_chk("R2 repl_lo", 8'h88, 32'h3333_3333);
    rd_chk("R2 repl_hi", 8'h8C, 32'h4444_4444);
    rd_chk("R2 mask_lo", 8'h90, 32'h5555_5555);
    rd_chk("R2 mask_hi", 8'h94, 32'h6666_6666);
    rd_chk("R2 type", 8'h98, 32'h7777_7777);
    wr(8'h9C, 32'hDEAD_BEEF);
    rd_chk("R2 hole reads zero", 8'h9C, 32'h0);
    wr(8'h85, 32'hDEAD_BEEF);
    rd_chk("R2 misaligned write ignored", 8'h84, 32'h2222_2222);
    rd_chk("R2 misaligned read zero", 8'h85, 32'h0);
    rd_chk("R2 neighbour w5 untouched", 8'hA0, 32'h0);
  endtask

  task automatic t_arm;
    set_win(2, 32'h4000_0000, 32'h0, 32'h5000_0000, 32'h0, 32'hF000_0000, 32'h0, 32'h0, 1'b0);
    look("R3 unarmed window", 64'h4000_0010, 1'b0, 3'd0, 64'h4000_0010, 1'b0);
    wr(8'h40, 32'h4000_0001);
    look("R3 armed window", 64'h4000_0010, 1'b1, 3'd2, 64'h5000_0010, 1'b0);
  endtask

  task automatic t_basic;
    set_win(0, 32'hE800_0000, 32'h0, 32'h0800_0000, 32'h0, 32'hF800_0000, 32'h0, 32'h0, 1'b1);
    look("R5 mid window", 64'hE812_3456, 1'b1, 3'd0, 64'h0812_3456, 1'b0);
    look("R4 low edge", 64'hE800_0000, 1'b1, 3'd0, 64'h0800_0000, 1'b0);
    look("R4 high edge", 64'hEFFF_FFFF, 1'b1, 3'd0, 64'h0FFF_FFFF, 1'b0);
    look("R7 below window", 64'hE7FF_FFFF, 1'b0, 3'd0, 64'hE7FF_FFFF, 1'b0);
    look("R7 above window", 64'hF000_0000, 1'b0, 3'd0, 64'hF000_0000, 1'b0);
    look("R5 upper bits kept", 64'h0000_0012_E812_3456, 1'b1, 3'd0, 64'h0000_0012_0812_3456, 1'b0);
  endtask

  task automatic t_wide;
    set_win(5, 32'h0000_0000, 32'h0000_0001, 32'h1234_0000, 32'h0000_00AB,
            32'hFFFF_0000, 32'hFFFF_FFFF, 32'h4, 1'b1);
    look("R4 R10 wide io", 64'h0000_0001_0000_BEEF, 1'b1, 3'd5, 64'h0000_00AB_1234_BEEF, 1'b1);
    look("R4 upper mismatch", 64'h0000_0002_0000_BEEF, 1'b0, 3'd0, 64'h0000_0002_0000_BEEF, 1'b0);
  endtask

  task automatic t_prio;
    set_win(3, 32'hE800_0000, 32'h0, 32'h3000_0000, 32'h0, 32'hF800_0000, 32'h0, 32'h4, 1'b1);
    look("R6 lowest wins", 64'hE812_3456, 1'b1, 3'd0, 64'h0812_3456, 1'b0);
    wr(8'h00, 32'hE800_0000);
    look("R6 R3 next after disarm", 64'hE812_3456, 1'b1, 3'd3, 64'h3012_3456, 1'b1);
    rd_chk("R3 disarm keeps mask", 8'h10, 32'hF800_0000);
    wr(8'h00, 32'hE800_0001);
    look("R6 rearmed wins", 64'hE812_3456, 1'b1, 3'd0, 64'h0812_3456, 1'b0);
  endtask

  task automatic t_bit0;
    set_win(7, 32'h1000_0000, 32'h0, 32'h2000_0000, 32'h0000_0003,
            32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h7, 1'b1);
    look("R4 R10 arm bit not compared", 64'h1000_0000, 1'b1, 3'd7, 64'h0000_0003_2000_0000, 1'b0);
    look("R4 odd address misses", 64'h1000_0001, 1'b0, 3'd0, 64'h1000_0001, 1'b0);
  endtask

  task automatic t_gate;
    en = 1'b0;
    look("R8 global off", 64'hE812_3456, 1'b0, 3'd0, 64'hE812_3456, 1'b0);
    en = 1'b1; byp = 1'b1;
    look("R9 bypass", 64'h0000_0001_0000_BEEF, 1'b0, 3'd0, 64'h0000_0001_0000_BEEF, 1'b0);
    en = 1'b0;
    look("R8 R9 both", 64'hE812_3456, 1'b0, 3'd0, 64'hE812_3456, 1'b0);
    en = 1'b1; byp = 1'b0;
    look("R8 restored", 64'hE812_3456, 1'b1, 3'd0, 64'h0812_3456, 1'b0);
  endtask

  task automatic t_hold;
    repeat (20) @(negedge clk);
    rd_chk("R11 repl_hi held", 8'hAC, 32'h0000_00AB);
    rd_chk("R11 type held", 8'hB8, 32'h4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_arm();
    t_basic();
    t_wide();
    t_prio();
    t_bit0();
    t_gate();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule